// File: doc/BRIEF.md
# DRAM Command Energy Accumulator

This block estimates how much energy the memory devices consume by watching what they are asked to do, not by measuring current. For every DIMM it receives, each clock cycle, a background state (idle with clock enable high, or idle with clock enable low) and single-cycle pulses for activate (which is costed together with its later precharge), read CAS and write CAS. Software programs a weight for each of these events and states, per DIMM, as a whole multiple of a base energy unit. Each cycle the weights that apply are summed, and the sum goes into a running energy total.

The base unit is 2^-(30+S) joules, where S is a programmable scale factor. The readable total is held in unsigned 18.14 fixed-point joules, so one count is 2^-14 J, about 61 uJ. A conversion stage divides the base-unit sum by 2^(16+S) and keeps the remainder below one output count internally, so that small per-cycle contributions still add up over time. The total wraps to zero at its maximum and keeps counting. Only reset clears it.

Register map (word addresses, 32-bit data): 0 = scale factor in bits [3:0]; 1 = energy total (read-only); 2+2d = DIMM d background weights; 3+2d = DIMM d command weights.

Top module: `dram_energy_acc`

## Requirements
- R1: After reset the energy total reads 0, the scale factor reads 3 and every weight word reads 0.
- R2: In each cycle where DIMM d has idle=1 and cke=1, that DIMM's 6-bit idle weight (background word bits [5:0]) is added in base units. Its power-down weight is not added in that cycle.
- R3: In each cycle where DIMM d has idle=1 and cke=0, that DIMM's 6-bit power-down weight (background word bits [11:6]) is added. Its idle weight is not added in that cycle.
- R4: Each cycle with an activate, read or write pulse for DIMM d adds that DIMM's 8-bit weight for the pulse. In the command word, activate is in bits [7:0], read in [15:8] and write in [23:16].
- R5: When a background state and one or more command pulses fall in the same cycle, every matching weight of every DIMM is added in that cycle.
- R6: The energy total equals floor(total base units / 2^(16+S)) in 18.14 joule format, with S taken from the scale factor field. The total changes only when some weight was added.
- R7: The remainder below one output count is carried from cycle to cycle, so the total follows the floor of the whole sum and not the sum of per-cycle floors.
- R8: The energy counter wraps modulo 2^CNT_W and keeps counting after the wrap.
- R9: Writes to the energy total address are ignored. Only reset clears the total.
- R10: The scale factor and the weight words read back what was last written to them, at the field positions given above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dimm_idle | input | N_DIMM | Per-DIMM flag: DIMM is idle this cycle |
| dimm_cke | input | N_DIMM | Per-DIMM clock enable level this cycle |
| cmd_act | input | N_DIMM | Per-DIMM activate pulse (activate and precharge costed together) |
| cmd_rd | input | N_DIMM | Per-DIMM read CAS pulse |
| cmd_wr | input | N_DIMM | Per-DIMM write CAS pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | ADDR_W | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | ADDR_W | Register read address |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_raddr |

## Verification
Background-state energy and command energy can be added in the same clock, both for one DIMM and across both DIMMs. The bench forces this overlap on purpose: it holds a DIMM idle while pulsing read or activate, and it also drives random mixes where every input may be high together. The result is judged by comparing the total read back against a bench model. That model adds up every weight that should apply in each driven cycle and applies the floor division only when the total is read.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int BG_W  = 6;   // background weight width
  localparam int CMD_W = 8;   // command weight width

  typedef struct packed {
    logic [CMD_W-1:0] wr_w;
    logic [CMD_W-1:0] rd_w;
    logic [CMD_W-1:0] act_w;
    logic [BG_W-1:0]  pd_w;
    logic [BG_W-1:0]  idle_w;
  } dimm_wt_t;

  localparam int ADDR_SF     = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_DIMM0  = 2;
endpackage

// File: rtl/dce_regfile.sv
module dce_regfile
  import dce_pkg::*;
#(
  parameter int N_DIMM = 2,
  parameter int SF_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [31:0]             wdata,
  input  logic [ADDR_W-1:0]       raddr,
  input  logic [31:0]             status_in,
  output logic [31:0]             rdata,
  output dimm_wt_t [N_DIMM-1:0]   wt_o,
  output logic [SF_W-1:0]         sf_o
);
  localparam int BGWORD_W  = 2 * BG_W;
  localparam int CMDWORD_W = 3 * CMD_W;

  dimm_wt_t [N_DIMM-1:0] wt_q, wt_nxt;
  logic [SF_W-1:0]       sf_q, sf_nxt;
  logic                  sf_en;
  logic [N_DIMM-1:0]     bg_en, cmd_en;
  logic                  unused_wdata;

  assign unused_wdata = ^wdata[31:CMDWORD_W];

  always_comb begin
    sf_en  = we && (waddr == ADDR_W'(ADDR_SF));
    sf_nxt = wdata[SF_W-1:0];
    wt_nxt = wt_q;
    for (int d = 0; d < N_DIMM; d++) begin
      bg_en[d]  = we && (waddr == ADDR_W'(ADDR_DIMM0 + 2*d));
      cmd_en[d] = we && (waddr == ADDR_W'(ADDR_DIMM0 + 2*d + 1));
      if (bg_en[d]) begin
        wt_nxt[d].idle_w = wdata[BG_W-1:0];
        wt_nxt[d].pd_w   = wdata[BGWORD_W-1:BG_W];
      end
      if (cmd_en[d]) begin
        wt_nxt[d].act_w = wdata[CMD_W-1:0];
        wt_nxt[d].rd_w  = wdata[2*CMD_W-1:CMD_W];
        wt_nxt[d].wr_w  = wdata[CMDWORD_W-1:2*CMD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= SF_W'(3);
    end else if (sf_en) begin
      sf_q <= sf_nxt;
    end
  end

  for (genvar g = 0; g < N_DIMM; g++) begin : g_wt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wt_q[g] <= '0;
      end else if (bg_en[g] || cmd_en[g]) begin
        wt_q[g] <= wt_nxt[g];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == ADDR_W'(ADDR_SF))     rdata = 32'(sf_q);
    if (raddr == ADDR_W'(ADDR_STATUS)) rdata = status_in;
    for (int d = 0; d < N_DIMM; d++) begin
      if (raddr == ADDR_W'(ADDR_DIMM0 + 2*d))
        rdata = 32'({wt_q[d].pd_w, wt_q[d].idle_w});
      if (raddr == ADDR_W'(ADDR_DIMM0 + 2*d + 1))
        rdata = 32'({wt_q[d].wr_w, wt_q[d].rd_w, wt_q[d].act_w});
    end
  end

  assign wt_o = wt_q;
  assign sf_o = sf_q;
endmodule

// File: rtl/dce_event_sum.sv
module dce_event_sum
  import dce_pkg::*;
#(
  parameter int N_DIMM = 2,
  parameter int INC_W  = 11
) (
  input  dimm_wt_t [N_DIMM-1:0] wt,
  input  logic [N_DIMM-1:0]     idle,
  input  logic [N_DIMM-1:0]     cke,
  input  logic [N_DIMM-1:0]     act,
  input  logic [N_DIMM-1:0]     rd,
  input  logic [N_DIMM-1:0]     wr,
  output logic [INC_W-1:0]      inc
);
  logic [INC_W-1:0] term [N_DIMM];

  for (genvar g = 0; g < N_DIMM; g++) begin : g_term
    always_comb begin
      term[g] = '0;
      if (idle[g] &&  cke[g]) term[g] = term[g] + INC_W'(wt[g].idle_w);
      if (idle[g] && !cke[g]) term[g] = term[g] + INC_W'(wt[g].pd_w);
      if (act[g])             term[g] = term[g] + INC_W'(wt[g].act_w);
      if (rd[g])              term[g] = term[g] + INC_W'(wt[g].rd_w);
      if (wr[g])              term[g] = term[g] + INC_W'(wt[g].wr_w);
    end
  end

  always_comb begin
    inc = '0;
    for (int d = 0; d < N_DIMM; d++) inc = inc + term[d];
  end
endmodule

// File: rtl/dce_convert.sv
module dce_convert #(
  parameter int INC_W      = 11,
  parameter int SF_W       = 4,
  parameter int CNT_W      = 32,
  parameter int UNIT_SHIFT = 16,
  parameter int FRAC_W     = UNIT_SHIFT + (2**SF_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc,
  input  logic [SF_W-1:0]   sf,
  output logic [CNT_W-1:0]  status,
  output logic [FRAC_W-1:0] frac
);
  localparam int SUM_W = ((FRAC_W > INC_W) ? FRAC_W : INC_W) + 1;

  logic [FRAC_W-1:0] frac_q, frac_nxt;
  logic [CNT_W-1:0]  status_q, status_nxt;
  logic [SUM_W-1:0]  sum_w, whole, mask;
  logic              upd;
  int                sh;

  always_comb begin
    sh         = UNIT_SHIFT + int'(sf);
    upd        = |inc;
    sum_w      = SUM_W'(frac_q) + SUM_W'(inc);
    whole      = sum_w >> sh;
    mask       = (SUM_W'(1) << sh) - SUM_W'(1);
    frac_nxt   = FRAC_W'(sum_w & mask);
    status_nxt = status_q + CNT_W'(whole);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q   <= '0;
      status_q <= '0;
    end else if (upd) begin
      frac_q   <= frac_nxt;
      status_q <= status_nxt;
    end
  end

  assign status = status_q;
  assign frac   = frac_q;
endmodule

// File: rtl/dram_energy_acc.sv
module dram_energy_acc
  import dce_pkg::*;
#(
  parameter int N_DIMM     = 2,
  parameter int SF_W       = 4,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 32,
  parameter int UNIT_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DIMM-1:0] dimm_idle,
  input  logic [N_DIMM-1:0] dimm_cke,
  input  logic [N_DIMM-1:0] cmd_act,
  input  logic [N_DIMM-1:0] cmd_rd,
  input  logic [N_DIMM-1:0] cmd_wr,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata
);
  localparam int DIMM_MAX = (2**BG_W - 1) + 3 * (2**CMD_W - 1);
  localparam int INC_W    = $clog2(N_DIMM * DIMM_MAX + 1);
  localparam int FRAC_W   = UNIT_SHIFT + (2**SF_W) - 1;

  logic [1:0]            rst_sync;
  logic                  rst_sync_n;
  dimm_wt_t [N_DIMM-1:0] wt;
  logic [SF_W-1:0]       sf_q;
  logic [INC_W-1:0]      inc;
  logic [CNT_W-1:0]      status;
  logic [FRAC_W-1:0]     conv_frac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  dce_regfile #(.N_DIMM(N_DIMM), .SF_W(SF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .waddr(cfg_waddr),
    .wdata(cfg_wdata), .raddr(cfg_raddr), .status_in(32'(status)),
    .rdata(cfg_rdata), .wt_o(wt), .sf_o(sf_q)
  );

  dce_event_sum #(.N_DIMM(N_DIMM), .INC_W(INC_W)) u_sum (
    .wt(wt), .idle(dimm_idle), .cke(dimm_cke), .act(cmd_act),
    .rd(cmd_rd), .wr(cmd_wr), .inc(inc)
  );

  dce_convert #(.INC_W(INC_W), .SF_W(SF_W), .CNT_W(CNT_W),
                .UNIT_SHIFT(UNIT_SHIFT), .FRAC_W(FRAC_W)) u_conv (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .sf(sf_q),
    .status(status), .frac(conv_frac)
  );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int N_DIMM     = 2,
  parameter int SF_W       = 4,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 32,
  parameter int UNIT_SHIFT = 16,
  parameter int FRAC_W     = UNIT_SHIFT + (2**SF_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_DIMM-1:0] idle,
  input logic [N_DIMM-1:0] act,
  input logic [N_DIMM-1:0] rd,
  input logic [N_DIMM-1:0] wr,
  input logic              we,
  input logic [ADDR_W-1:0] waddr,
  input logic [CNT_W-1:0]  status,
  input logic [FRAC_W-1:0] frac,
  input logic [SF_W-1:0]   sf
);
  logic [CNT_W-1:0] prev_status, delta;
  logic [FRAC_W:0]  lim;
  logic             quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_status <= '0;
    else        prev_status <= status;
  end
  assign delta = status - prev_status;
  assign lim   = (FRAC_W+1)'(1) << (UNIT_SHIFT + int'(sf));
  assign quiet = !(|idle) && !(|act) && !(|rd) && !(|wr);

  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (status == '0); // R1
  end

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(status)); // R6

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && we && waddr == ADDR_W'(1)) |=> $stable(status)); // R9

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    delta <= CNT_W'(1)); // R8

  AST_REMAINDER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, frac} < lim); // R7
endmodule

bind dram_energy_acc dce_checker #(
  .N_DIMM(N_DIMM), .SF_W(SF_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
  .UNIT_SHIFT(UNIT_SHIFT), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .idle(dimm_idle), .act(cmd_act),
  .rd(cmd_rd), .wr(cmd_wr), .we(cfg_we), .waddr(cfg_waddr),
  .status(status), .frac(conv_frac), .sf(sf_q)
);

// File: tb/tb_dram_energy_acc.sv
module tb_dram_energy_acc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  dimm_idle, dimm_cke, cmd_act, cmd_rd, cmd_wr;
  logic        cfg_we;
  logic [3:0]  cfg_waddr, cfg_raddr;
  logic [31:0] cfg_wdata, rdata, rdata_s;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     m_idle[2], m_pd[2], m_act[2], m_rd[2], m_wr[2];
  int     m_sf;
  longint total;

  always #4 clk = ~clk;

  dram_energy_acc dut (
    .clk(clk), .rst_n(rst_n), .dimm_idle(dimm_idle), .dimm_cke(dimm_cke),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cfg_we(cfg_we),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(rdata)
  );

  dram_energy_acc #(.CNT_W(8)) dut_small (
    .clk(clk), .rst_n(rst_n), .dimm_idle(dimm_idle), .dimm_cke(dimm_cke),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cfg_we(cfg_we),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(rdata_s)
  );

  function automatic longint cyc_units(logic [1:0] idl, logic [1:0] ck,
                                       logic [1:0] a, logic [1:0] r, logic [1:0] w);
    longint u = 0;
    for (int d = 0; d < 2; d++) begin
      if (idl[d] &&  ck[d]) u += m_idle[d];
      if (idl[d] && !ck[d]) u += m_pd[d];
      if (a[d]) u += m_act[d];
      if (r[d]) u += m_rd[d];
      if (w[d]) u += m_wr[d];
    end
    return u;
  endfunction

  function automatic longint exp_total(int width);
    longint v = total >> (16 + m_sf);
    return v & ((longint'(1) << width) - 1);
  endfunction

  task automatic zero_in();
    dimm_idle = '0; dimm_cke = '0; cmd_act = '0; cmd_rd = '0; cmd_wr = '0;
  endtask

  task automatic cyc(logic [1:0] idl, logic [1:0] ck, logic [1:0] a,
                     logic [1:0] r, logic [1:0] w);
    @(negedge clk);
    dimm_idle = idl; dimm_cke = ck; cmd_act = a; cmd_rd = r; cmd_wr = w;
    total += cyc_units(idl, ck, a, r, w);
  endtask

  task automatic rand_cyc();
    cyc(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
  endtask

  task automatic wreg(int addr, logic [31:0] data);
    @(negedge clk);
    zero_in();
    cfg_we = 1'b1; cfg_waddr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_sf(int s);
    wreg(0, 32'(s));
    m_sf = s;
  endtask

  task automatic set_w(int d, int idl, int pd, int a, int r, int w);
    wreg(2 + 2*d, 32'((pd << 6) | idl));
    wreg(3 + 2*d, 32'((w << 16) | (r << 8) | a));
    m_idle[d] = idl; m_pd[d] = pd; m_act[d] = a; m_rd[d] = r; m_wr[d] = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    zero_in();
    cfg_we = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      m_idle[d] = 0; m_pd[d] = 0; m_act[d] = 0; m_rd[d] = 0; m_wr[d] = 0;
    end
    m_sf  = 3;
    total = 0;
  endtask

  task automatic rd_chk(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    zero_in();
    cfg_raddr = 4'(addr);
    #1;
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, addr, rdata, exp);
    end
  endtask

  task automatic chk_status(string tag);
    logic [31:0] e32, e8;
    @(negedge clk);
    zero_in();
    cfg_raddr = 4'd1;
    #1;
    e32 = 32'(exp_total(32));
    e8  = 32'(exp_total(8));
    n_tests++;
    if (rdata !== e32 || rdata_s !== e8) begin
      n_fail++;
      $display("FAIL %s total: got %h/%h expected %h/%h", tag, rdata, rdata_s, e32, e8);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    zero_in();
    cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
    rst_n = 1'b0;
    do_reset();

    // R1: reset values
    rd_chk(0, 32'd3, "R1 scale");
    rd_chk(1, 32'd0, "R1 total");
    for (int a = 2; a < 6; a++) rd_chk(a, 32'd0, "R1 weight");

    // R10: readback of scale and weight fields
    set_sf(0);
    set_w(0, 63, 0, 0, 0, 0);
    set_w(1, 21, 44, 200, 150, 100);
    rd_chk(0, 32'd0, "R10 scale");
    rd_chk(2, 32'd63, "R10 dimm0 bg");
    rd_chk(4, 32'((44 << 6) | 21), "R10 dimm1 bg");
    rd_chk(5, 32'((100 << 16) | (150 << 8) | 200), "R10 dimm1 cmd");

    // R2: idle with cke high on dimm0 only, 63 * 2100 units
    set_w(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2100; i++) cyc(2'b01, 2'b01, 2'b00, 2'b00, 2'b00);
    chk_status("R2");

    // R3: power-down on dimm0, idle weight present but must not count
    do_reset();
    set_sf(0);
    set_w(0, 63, 37, 0, 0, 0);
    for (int i = 0; i < 3600; i++) cyc(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_status("R3");

    // R7: 50 * 1311 = 65550 units, one count though each cycle alone is far below it
    do_reset();
    set_sf(0);
    set_w(1, 0, 50, 0, 0, 0);
    for (int i = 0; i < 1311; i++) cyc(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_status("R7");

    // R4: command pulses only on dimm1
    do_reset();
    set_sf(0);
    set_w(1, 0, 0, 200, 150, 100);
    for (int i = 0; i < 1500; i++)
      cyc(2'b00, 2'b00, {1'($urandom), 1'b0}, {1'($urandom), 1'b0}, {1'($urandom), 1'b0});
    chk_status("R4");

    // R5: state and command together, both DIMMs
    do_reset();
    set_sf(0);
    set_w(0, 40, 9, 0, 170, 0);
    set_w(1, 5, 30, 220, 0, 0);
    for (int i = 0; i < 1000; i++) cyc(2'b11, 2'b01, 2'b10, 2'b01, 2'b00);
    chk_status("R5");

    // R6: random mixes at several scale factors, R9 write to total
    for (int s = 1; s <= 3; s++) begin
      do_reset();
      if (s != 3) set_sf(s);
      for (int d = 0; d < 2; d++)
        set_w(d, $urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 255),
              $urandom_range(0, 255), $urandom_range(0, 255));
      for (int k = 0; k < 6; k++) begin
        for (int i = 0; i < 500; i++) rand_cyc();
        chk_status("R6");
      end
      wreg(1, 32'hFFFF_FFFF);
      chk_status("R9 write ignored");
    end

    // R9: reset clears the total
    do_reset();
    chk_status("R9 reset clear");

    // R8: maximum weights, small counter wraps
    set_sf(0);
    set_w(0, 63, 63, 255, 255, 255);
    set_w(1, 63, 63, 255, 255, 255);
    for (int i = 0; i < 11000; i++) cyc(2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
    chk_status("R8 wrap");
    for (int i = 0; i < 200; i++) rand_cyc();
    chk_status("R8 after wrap");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule